// File: doc/BRIEF.md
# Frame-Aligned Multi-Rate Clock Divider

This block runs on a single high-rate master clock, nominally 155.52 MHz, and derives a set of slower clocks from it. Two outputs each run at one of three binary sub-rates of the master clock. A frame output runs at 8 kHz and a multiframe output at 2 kHz. Every derived clock starts its period at the same master-clock cycle as the frame clock. A pass-through enable for the undivided master clock is also provided. Each output pin is modelled as a data bit plus an output enable. A low enable stands for a tri-stated pin.

Software sets each output through a small synchronous write port. A write first lands in a staged copy of the select. The staged copies are moved into the active copies together, on the first cycle of the next frame, so a rate or width change never cuts a period short. A frame-sync strobe from outside forces the frame and multiframe counters back to phase zero and applies the staged selects at once. This lets a slave device follow the frame timing of a master.

The frame length in master cycles (`FRAME_DIV`, default 19440) and the number of frames in a multiframe (`MF_LEN`, default 4) are parameters. `FRAME_DIV` must be a multiple of 8 and at least 64. `MF_LEN` must be even.

Top module: `frame_clock_divider`

## Requirements
- R1: While `rst_n` is low, every enable and every clock output is low. After reset, all selects read as disabled and the frame phase is 0.
- R2: A write with `wr_en` high updates one register. The registers are:
  - address 0, bit 0: master pass-through enable. It reaches `main_oe` on the cycle after the write.
  - address 1, bits 1:0: rate A select.
  - address 2, bits 1:0: rate B select.
  - address 3, bits 5:0: frame select.
  - address 4, bits 5:0: multiframe select.
- R3: Rate select encoding:
  - 0: disabled.
  - 1: divide by 8.
  - 2: divide by 4.
  - 3: divide by 2.

  An enabled rate output is high for the first half of each of its periods, and its periods start at frame phase 0.
- R4: Frame select encoding:
  - 0: disabled.
  - 1: high for frame phases 0 to `FRAME_DIV/2`-1.
  - W from 2 to 63: high for frame phases 0 to W-1.
- R5: The multiframe period is `MF_LEN` frames. Multiframe select encoding:
  - 0: disabled.
  - 1: high for the first `MF_LEN/2` frames.
  - W from 2 to 63: high for phases 0 to W-1 of frame 0 only.
- R6: Every rising edge of the multiframe output falls on frame phase 0, where an enabled frame output is high. Every rising edge of the frame output finds each enabled rate output high.
- R7: Select values written to addresses 1 to 4 take effect on the first cycle of the next frame. Until then, the outputs keep their previous behaviour.
- R8: When `fsync_in` is sampled high, the next cycle is phase 0 of frame 0, and the staged selects become active in that same cycle.
- R9: A disabled output has its enable low and its data low.
- R10: Writes to addresses 5, 6 and 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fsync_in | input | 1 | External frame-sync strobe |
| main_oe | output | 1 | Pass-through master clock enable |
| rate_a_out | output | 1 | Rate A clock |
| rate_a_oe | output | 1 | Rate A enable |
| rate_b_out | output | 1 | Rate B clock |
| rate_b_oe | output | 1 | Rate B enable |
| frame_out | output | 1 | Frame (8 kHz) clock |
| frame_oe | output | 1 | Frame clock enable |
| mframe_out | output | 1 | Multiframe (2 kHz) clock |
| mframe_oe | output | 1 | Multiframe clock enable |

## Verification
The bench uses a short frame of 80 cycles with 4 frames per multiframe and sweeps eight select configurations. Between them, these configurations cover every rate code on both rate outputs, disabled, half-duty and several pulse widths for the frame and multiframe outputs. Each configuration is checked cycle by cycle over two full multiframes against phases computed in the bench. This separates the divider ratios from one another and the half-duty mode from the pulse mode. It also separates the frame-0-only pulse of the multiframe output from a pulse that repeats every frame.

A separate sequence changes the selects mid-frame without a strobe, which shows whether the change waits for the frame boundary. Another sequence strobes `fsync_in` at an odd phase, which shows whether the counters realign. Writes to the unused addresses are made with live outputs running, to show they leave those outputs untouched.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 6;
  localparam int RATE_N = 2;

  typedef enum logic [1:0] {
    RATE_OFF  = 2'd0,
    RATE_DIV8 = 2'd1,
    RATE_DIV4 = 2'd2,
    RATE_DIV2 = 2'd3
  } rate_sel_e;

  localparam logic [ADDR_W-1:0] A_MAIN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RATE_A = 3'd1;
  localparam logic [ADDR_W-1:0] A_RATE_B = 3'd2;
  localparam logic [ADDR_W-1:0] A_FRAME  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MFRAME = 3'd4;
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              apply,
  output logic              main_en,
  output rate_sel_e         rate_sel [RATE_N],
  output logic [SEL_W-1:0]  frame_sel,
  output logic [SEL_W-1:0]  mf_sel
);
  rate_sel_e        stg_rate [RATE_N];
  logic [SEL_W-1:0] stg_frame;
  logic [SEL_W-1:0] stg_mf;

  // staged copies: written immediately, unknown addresses dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_en   <= 1'b0;
      stg_frame <= '0;
      stg_mf    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MAIN:   main_en   <= wr_data[0];
        A_FRAME:  stg_frame <= wr_data[SEL_W-1:0];
        A_MFRAME: stg_mf    <= wr_data[SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < RATE_N; g++) begin : g_rate_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = A_RATE_A + ADDR_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_rate[g] <= RATE_OFF;
        rate_sel[g] <= RATE_OFF;
      end else begin
        if (wr_en && wr_addr == MY_ADDR)
          stg_rate[g] <= rate_sel_e'(wr_data[1:0]);
        if (apply)
          rate_sel[g] <= stg_rate[g];
      end
    end
  end

  // active copies: moved only at a frame boundary or a sync strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_sel <= '0;
      mf_sel    <= '0;
    end else if (apply) begin
      frame_sel <= stg_frame;
      mf_sel    <= stg_mf;
    end
  end
endmodule

// File: rtl/fcd_timer.sv
module fcd_timer #(
  parameter int FRAME_DIV = 19440,
  parameter int MF_LEN    = 4,
  localparam int FW = $clog2(FRAME_DIV),
  localparam int MW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic [FW-1:0] frm_cnt,
  output logic [MW-1:0] mf_cnt,
  output logic          apply,
  output logic          frame_start,
  output logic          frm_first_half,
  output logic          mf_first_half,
  output logic          mf_zero
);
  localparam logic [FW-1:0] FRM_LAST = FW'(FRAME_DIV - 1);
  localparam logic [FW-1:0] FRM_HALF = FW'(FRAME_DIV / 2);
  localparam logic [MW-1:0] MF_LAST  = MW'(MF_LEN - 1);
  localparam logic [MW-1:0] MF_HALF  = MW'(MF_LEN / 2);

  logic frm_wrap;
  assign frm_wrap = (frm_cnt == FRM_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_cnt <= '0;
      mf_cnt  <= '0;
    end else if (fsync) begin
      frm_cnt <= '0;
      mf_cnt  <= '0;
    end else if (frm_wrap) begin
      frm_cnt <= '0;
      mf_cnt  <= (mf_cnt == MF_LAST) ? '0 : mf_cnt + 1'b1;
    end else begin
      frm_cnt <= frm_cnt + 1'b1;
    end
  end

  assign apply          = fsync || frm_wrap;
  assign frame_start    = (frm_cnt == '0);
  assign frm_first_half = (frm_cnt < FRM_HALF);
  assign mf_first_half  = (mf_cnt < MF_HALF);
  assign mf_zero        = (mf_cnt == '0);
endmodule

// File: rtl/fcd_rate_gen.sv
module fcd_rate_gen
  import fcd_pkg::*;
(
  input  logic [2:0] phase_lo,
  input  rate_sel_e  sel,
  output logic       clk_out,
  output logic       oe
);
  always_comb begin
    case (sel)
      RATE_DIV8: clk_out = ~phase_lo[2];
      RATE_DIV4: clk_out = ~phase_lo[1];
      RATE_DIV2: clk_out = ~phase_lo[0];
      default:   clk_out = 1'b0;
    endcase
  end
  assign oe = (sel != RATE_OFF);
endmodule

// File: rtl/fcd_pulse_gen.sv
module fcd_pulse_gen
  import fcd_pkg::*;
#(
  parameter int FW = 15
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [FW-1:0]    phase,
  input  logic             half_on,
  input  logic             zone,
  output logic             clk_out,
  output logic             oe
);
  logic wide;
  assign wide = (phase < FW'(sel));

  always_comb begin
    if (sel == '0)           clk_out = 1'b0;
    else if (sel == SEL_W'(1)) clk_out = half_on;
    else                     clk_out = zone && wide;
  end
  assign oe = (sel != '0);
endmodule

// File: rtl/frame_clock_divider.sv
module frame_clock_divider
  import fcd_pkg::*;
#(
  parameter int FRAME_DIV = 19440,
  parameter int MF_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fsync_in,
  output logic              main_oe,
  output logic              rate_a_out,
  output logic              rate_a_oe,
  output logic              rate_b_out,
  output logic              rate_b_oe,
  output logic              frame_out,
  output logic              frame_oe,
  output logic              mframe_out,
  output logic              mframe_oe
);
  localparam int FW = $clog2(FRAME_DIV);
  localparam int MW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;

  logic [FW-1:0]    frm_cnt;
  logic [MW-1:0]    mf_cnt;
  logic             apply, frame_start, frm_first_half, mf_first_half, mf_zero;
  rate_sel_e        rate_sel [RATE_N];
  logic [SEL_W-1:0] frame_sel, mf_sel;
  logic [RATE_N-1:0] r_out, r_oe;

  fcd_timer #(.FRAME_DIV(FRAME_DIV), .MF_LEN(MF_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync_in),
    .frm_cnt(frm_cnt), .mf_cnt(mf_cnt), .apply(apply),
    .frame_start(frame_start), .frm_first_half(frm_first_half),
    .mf_first_half(mf_first_half), .mf_zero(mf_zero)
  );

  fcd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .apply(apply), .main_en(main_oe),
    .rate_sel(rate_sel), .frame_sel(frame_sel), .mf_sel(mf_sel)
  );

  for (genvar g = 0; g < RATE_N; g++) begin : g_rate
    fcd_rate_gen u_rate (
      .phase_lo(frm_cnt[2:0]), .sel(rate_sel[g]),
      .clk_out(r_out[g]), .oe(r_oe[g])
    );
  end

  fcd_pulse_gen #(.FW(FW)) u_frame (
    .sel(frame_sel), .phase(frm_cnt), .half_on(frm_first_half),
    .zone(1'b1), .clk_out(frame_out), .oe(frame_oe)
  );

  fcd_pulse_gen #(.FW(FW)) u_mframe (
    .sel(mf_sel), .phase(frm_cnt), .half_on(mf_first_half),
    .zone(mf_zero), .clk_out(mframe_out), .oe(mframe_oe)
  );

  assign rate_a_out = r_out[0];
  assign rate_a_oe  = r_oe[0];
  assign rate_b_out = r_out[1];
  assign rate_b_oe  = r_oe[1];
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic clk,
  input logic rst_n,
  input logic fsync_in,
  input logic frame_start,
  input logic rate_a_out, input logic rate_a_oe,
  input logic rate_b_out, input logic rate_b_oe,
  input logic frame_out,  input logic frame_oe,
  input logic mframe_out, input logic mframe_oe
);
  // R9
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_a_oe || !rate_a_out) && (rate_b_oe || !rate_b_out) &&
    (frame_oe || !frame_out) && (mframe_oe || !mframe_out));

  // R6
  assert_mframe_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mframe_out) |-> frame_start && (!frame_oe || frame_out));

  // R6
  assert_rate_high_at_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) |-> frame_start && (!rate_a_oe || rate_a_out) &&
                         (!rate_b_oe || rate_b_out));

  // R7
  assert_sel_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rate_a_oe, rate_b_oe, frame_oe, mframe_oe}) |-> frame_start);

  // R8
  assert_fsync_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_in |=> frame_start);
endmodule

bind frame_clock_divider fcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .frame_start(frame_start),
  .rate_a_out(rate_a_out), .rate_a_oe(rate_a_oe),
  .rate_b_out(rate_b_out), .rate_b_oe(rate_b_oe),
  .frame_out(frame_out), .frame_oe(frame_oe),
  .mframe_out(mframe_out), .mframe_oe(mframe_oe)
);

// File: tb/frame_clock_divider_test.sv
module frame_clock_divider_test;
  localparam int FD = 80;
  localparam int MF = 4;
  localparam int SF = FD * MF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic fsync_in = 1'b0;
  logic main_oe, rate_a_out, rate_a_oe, rate_b_out, rate_b_oe;
  logic frame_out, frame_oe, mframe_out, mframe_oe;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  frame_clock_divider #(.FRAME_DIV(FD), .MF_LEN(MF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsync_in(fsync_in), .main_oe(main_oe),
    .rate_a_out(rate_a_out), .rate_a_oe(rate_a_oe),
    .rate_b_out(rate_b_out), .rate_b_oe(rate_b_oe),
    .frame_out(frame_out), .frame_oe(frame_oe),
    .mframe_out(mframe_out), .mframe_oe(mframe_oe)
  );

  // bench model of the requirements: phase count and staged/active selects
  int k;
  int s_ra, s_rb, s_fr, s_mf, a_ra, a_rb, a_fr, a_mf;
  bit m_main;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k <= 0; m_main <= 0;
      s_ra <= 0; s_rb <= 0; s_fr <= 0; s_mf <= 0;
      a_ra <= 0; a_rb <= 0; a_fr <= 0; a_mf <= 0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_main <= wr_data[0];
          3'd1: s_ra <= int'(wr_data[1:0]);
          3'd2: s_rb <= int'(wr_data[1:0]);
          3'd3: s_fr <= int'(wr_data[5:0]);
          3'd4: s_mf <= int'(wr_data[5:0]);
          default: ;
        endcase
      end
      if (fsync_in || (k % FD) == FD - 1) begin
        a_ra <= s_ra; a_rb <= s_rb; a_fr <= s_fr; a_mf <= s_mf;
      end
      k <= fsync_in ? 0 : ((k == SF - 1) ? 0 : k + 1);
    end
  end

  function automatic bit exp_rate(int sel, int ph);
    case (sel)
      1: return ((ph / 4) % 2) == 0;
      2: return ((ph / 2) % 2) == 0;
      3: return (ph % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_frame(int sel, int ph);
    if (sel == 0) return 1'b0;
    if (sel == 1) return ph < FD / 2;
    return ph < sel;
  endfunction

  function automatic bit exp_mf(int sel, int fr, int ph);
    if (sel == 0) return 1'b0;
    if (sel == 1) return fr < MF / 2;
    return (fr == 0) && (ph < sel);
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at k=%0d: actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  // compare all outputs once, at a negedge
  task automatic cmp_all();
    int ph = k % FD;
    int fr = k / FD;
    chk("R2", {1'b0, main_oe}, {1'b0, m_main});
    chk("R3", {rate_a_oe, rate_a_out}, {a_ra != 0, exp_rate(a_ra, ph)});
    chk("R3", {rate_b_oe, rate_b_out}, {a_rb != 0, exp_rate(a_rb, ph)});
    chk("R4", {frame_oe, frame_out}, {a_fr != 0, exp_frame(a_fr, ph)});
    chk("R5", {mframe_oe, mframe_out}, {a_mf != 0, exp_mf(a_mf, fr, ph)});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cmp_all();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    cmp_all();
    wr_en = 1'b0;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    fsync_in = 1'b1;
    @(negedge clk);
    fsync_in = 1'b0;
    // R8: next cycle is phase 0 of frame 0
    chk("R8", {1'b0, k == 0}, 2'b01);
    cmp_all();
  endtask

  task automatic to_phase(int ph);
    while ((k % FD) != ph) run(1);
  endtask

  initial begin
    int fsel [8] = '{0, 1, 2, 5, 63, 1, 17, 40};
    int msel [8] = '{1, 0, 3, 1, 63, 2, 1, 9};
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {rate_a_oe, rate_a_out}, 2'b00);
    chk("R1", {rate_b_oe, rate_b_out}, 2'b00);
    chk("R1", {frame_oe, frame_out}, 2'b00);
    chk("R1", {mframe_oe, mframe_out}, 2'b00);
    chk("R1", {1'b0, main_oe}, 2'b00);
    rst_n = 1'b1;
    // R9: all disabled for a whole multiframe
    run(SF);
    // configuration sweep (R3 R4 R5 R6 R8)
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 8'(c % 2));
      wr(3'd1, 8'(c % 4));
      wr(3'd2, 8'((c + 1) % 4));
      wr(3'd3, 8'(fsel[c]));
      wr(3'd4, 8'(msel[c]));
      sync_pulse();
      run(2 * SF);
    end
    // R7: mid-frame change waits for the frame boundary
    to_phase(30);
    wr(3'd3, 8'd0);
    wr(3'd1, 8'd0);
    chk("R7", {frame_oe, rate_a_oe}, 2'b11);
    to_phase(0);
    chk("R7", {frame_oe, rate_a_oe}, 2'b00);
    run(FD);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'd3);
    to_phase(0);
    run(SF);
    // R10: unused addresses leave live outputs alone
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00);
    to_phase(1);
    chk("R10", {frame_oe, rate_a_oe}, 2'b11);
    run(SF);
    // R8: sync at an odd phase realigns everything
    to_phase(37);
    sync_pulse();
    chk("R8", {frame_oe, frame_out}, 2'b11);
    run(SF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule